// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic heart of a small accumulator machine. It keeps a single working register, the accumulator. On each step the sequencer presents a byte on the data bus, picks an operation and raises a write strobe. The chosen result is then written back into the accumulator on the next rising clock edge. Add, OR and AND combine the accumulator with the bus byte. Invert works on the accumulator alone. Load copies the bus byte through unchanged.

Two flags describe the value the accumulator holds now, not the value the datapath is computing: a sign flag and a zero flag. The accumulator output also feeds the store path to memory.

The data input has no back-pressure. There is no ready signal, and a step is taken in every cycle that the strobe is high. The sequencer must hold the bus byte and the operation code steady around that edge.

Top module: `acc_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the accumulator to 0x00. This leaves the zero flag at 1 and the sign flag at 0, and reset wins over the write strobe.
- R2: While `wr_en` is low, the accumulator keeps its value, whatever the bus and the operation code do.
- R3: Operation code 0 (load) with `wr_en` high writes the bus byte into the accumulator unchanged.
- R4: Operation code 1 (add) writes (accumulator + bus) modulo 256. Any carry out of bit 7 is dropped.
- R5: Operation code 2 (or) writes the bitwise OR of the accumulator and the bus byte.
- R6: Operation code 3 (and) writes the bitwise AND of the accumulator and the bus byte.
- R7: Operation code 4 (invert) writes the bitwise complement of the accumulator. The bus byte has no effect on the result.
- R8: The sign flag `neg` always equals bit 7 of the accumulator output.
- R9: The zero flag `zero` is 1 exactly when the accumulator output is 0x00.
- R10: Operation codes 5, 6 and 7 are not defined. With `wr_en` high they leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the sequencer |
| op_code | input | 3 | Operation: 0 load, 1 add, 2 or, 3 and, 4 invert |
| bus_in | input | 8 | Data bus byte |
| acc | output | 8 | Accumulator value, also the store path |
| neg | output | 1 | Sign flag (accumulator bit 7) |
| zero | output | 1 | Zero flag (accumulator equal to 0x00) |

## Verification
The accumulator is the block's only state, and every port shows it directly. A wrong write, a missed hold or a corrupted result therefore appears on `acc` and on the flags in the cycle right after the faulty edge. Because the next operations chain on that value, the error then keeps propagating. The bench compares `acc`, `neg` and `zero` to a behavioural model after every clock. A bad result is caught one edge after it happens. Faults in the invert and undefined-code paths are brought out by changing the bus byte at the same moment, so that a leaked bus operand would become visible.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_OR   = 3'd2,
    OP_AND  = 3'd3,
    OP_INV  = 3'd4
  } op_e;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return code <= OP_INV;
  endfunction

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    acc_q,
  input  logic [W-1:0]    bus_in,
  input  logic [OP_W-1:0] op_code,
  output logic [W-1:0]    result,
  output logic            legal
);

  logic [W-1:0] or_lane;
  logic [W-1:0] and_lane;
  logic [W-1:0] inv_lane;
  logic [W-1:0] sum;

  // Per-bit logic lanes
  for (genvar b = 0; b < W; b++) begin : g_lane
    assign or_lane[b]  = acc_q[b] | bus_in[b];
    assign and_lane[b] = acc_q[b] & bus_in[b];
    assign inv_lane[b] = ~acc_q[b];
  end

  // Modulo-2^W adder; carry out is dropped
  assign sum   = acc_q + bus_in;
  assign legal = op_is_legal(op_code);

  always_comb begin
    result = acc_q;
    unique case (op_code)
      OP_LOAD: result = bus_in;
      OP_ADD:  result = sum;
      OP_OR:   result = or_lane;
      OP_AND:  result = and_lane;
      OP_INV:  result = inv_lane;
      default: result = acc_q;
    endcase
  end

endmodule

// File: rtl/acc_alu_reg.sv
module acc_alu_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_q,
  output logic         neg,
  output logic         zero
);

  localparam int MSB = W - 1;

  assign neg  = acc_q[MSB];
  assign zero = ~|acc_q;

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OP_W-1:0] op_code,
  input  logic [W-1:0]    bus_in,
  output logic [W-1:0]    acc,
  output logic            neg,
  output logic            zero
);

  logic [W-1:0] acc_q;
  logic [W-1:0] result;
  logic         legal;

  acc_alu_core #(.W(W)) u_core (
    .acc_q   (acc_q),
    .bus_in  (bus_in),
    .op_code (op_code),
    .result  (result),
    .legal   (legal)
  );

  acc_alu_reg #(.W(W)) u_acc (
    .clk (clk),
    .rst (rst),
    .we  (wr_en & legal),
    .d   (result),
    .q   (acc_q)
  );

  acc_alu_flags #(.W(W)) u_flags (
    .acc_q (acc_q),
    .neg   (neg),
    .zero  (zero)
  );

  assign acc = acc_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [OP_W-1:0] op_code,
  input logic [W-1:0]    bus_in,
  input logic [W-1:0]    acc,
  input logic            neg,
  input logic            zero
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (acc == '0));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(acc));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == OP_LOAD) |=> (acc == $past(bus_in)));

  p_add_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == OP_ADD) |=> (acc == W'($past(acc) + $past(bus_in))));

  p_or_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == OP_OR) |=> (acc == ($past(acc) | $past(bus_in))));

  p_and_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == OP_AND) |=> (acc == ($past(acc) & $past(bus_in))));

  p_invert_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code == OP_INV) |=> (acc == ~$past(acc)));

  p_sign_flag_r8: assert property (@(posedge clk) disable iff (rst)
    neg == acc[W-1]);

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
    zero == (acc == '0));

  p_undefined_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_code > OP_INV) |=> $stable(acc));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .op_code (op_code),
  .bus_in  (bus_in),
  .acc     (acc),
  .neg     (neg),
  .zero    (zero)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] acc;
  logic       neg;
  logic       zero;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  acc_alu uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .op_code (op_code),
    .bus_in  (bus_in),
    .acc     (acc),
    .neg     (neg),
    .zero    (zero)
  );

  task automatic step(input bit r, input bit we, input int op, input int b, input string tag);
    @(negedge clk);
    rst = r; wr_en = we; op_code = 3'(op); bus_in = 8'(b);
    @(posedge clk);
    if (r) model = 0;
    else if (we) begin
      case (op)
        0: model = b;
        1: model = (model + b) % 256;
        2: model = model | b;
        3: model = model & b;
        4: model = 255 - model;
        default: ;
      endcase
    end
    #1;
    checks++;
    if (acc !== 8'(model) || neg !== (model >= 128) || zero !== (model == 0)) begin
      fails++;
      $display("FAIL %s: acc=%02h neg=%b zero=%b expected acc=%02h neg=%b zero=%b",
               tag, acc, neg, zero, 8'(model), model >= 128, model == 0);
    end
  endtask

  function automatic string tag_of(bit we, int op);
    if (!we) return "R2";
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R10";
    endcase
  endfunction

  initial begin
    step(1, 1, 0, 8'hAA, "R1 reset");
    step(1, 0, 0, 8'h00, "R1 reset");
    step(0, 1, 0, 8'h3C, "R3 load");
    step(0, 0, 1, 8'hFF, "R2 hold");
    step(0, 0, 4, 8'h12, "R2 hold");
    step(0, 1, 1, 8'h10, "R4 add");
    step(0, 1, 1, 8'hC0, "R4 add wrap");
    step(0, 1, 0, 8'h80, "R8 sign");
    step(0, 1, 2, 8'h05, "R5 or");
    step(0, 1, 3, 8'h0F, "R6 and");
    step(0, 1, 4, 8'hFF, "R7 invert bus ff");
    step(0, 1, 4, 8'h00, "R7 invert bus 00");
    step(0, 1, 0, 8'h00, "R9 zero");
    step(0, 1, 1, 8'h00, "R9 zero add");
    step(0, 1, 0, 8'h5A, "R3 load");
    step(0, 1, 5, 8'hFF, "R10 code 5");
    step(0, 1, 6, 8'h00, "R10 code 6");
    step(0, 1, 7, 8'h81, "R10 code 7");
    step(0, 1, 0, 8'hFF, "R8 sign");
    step(0, 1, 1, 8'h01, "R4 R9 wrap to zero");
    step(0, 1, 0, 8'h77, "R3 load");
    step(1, 1, 1, 8'h22, "R1 reset over strobe");
    for (int i = 0; i < 400; i++) begin
      bit we;
      int op;
      we = ($urandom % 4) != 0;
      op = $urandom % 8;
      step(0, we, op, $urandom % 256, tag_of(we, op));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule